// File: doc/BRIEF.md
# RTC Interrupt and Frequency-Output Controller

This block drives one active-low shared pin, `irq_fout_n`, that carries either a square wave derived from a 32768 Hz oscillator or an alarm interrupt. An 8-bit control register chooses the output frequency and the alarm mode, and says whether the pin is silenced in battery mode. A status register holds three sticky flags: battery, alarm and event. It also holds an auto-clear bit. When that bit is set, the three flags are wiped after a completed status read.

The oscillator arrives as a level on `osc32k`, already synchronous to `clk`. Each rising edge is one tick. From the tick, a 20-bit divider makes every selectable rate from 4096 Hz down to 1/32 Hz. The 32768 Hz selection passes the oscillator level through directly. Alarm matches, event detections and battery mode come from neighbouring logic as one-cycle strobes or levels. The pin is registered, so it follows its sources one `clk` cycle later.

Top module: `rtc_irq_fout`

## Requirements
- R1: After reset the pin is high, both registers read 0x00, and the divider and pulse timer are idle.
- R2: A write with `bus_sel`=0 loads the control register. Its fields, from bit 7 down, are: pulse mode (7), alarm enable (6), low-power (5), battery silence (4) and frequency code (3:0). `ctrl_rd` returns the stored value.
- R3: Frequency code 0 turns the wave off. Codes 1 to 15 select, in order: 32768, 4096, 1024, 64, 32, 16, 8, 4, 2, 1, 1/2, 1/4, 1/8, 1/16 and 1/32 Hz. Each is a 50% square wave. Any write that changes the code clears the divider, so the wave starts with a full low half-period.
- R4: While the code is non-zero, the wave owns the pin and alarm matches are ignored: no pulse, and no alarm flag. With alarm enable at 0, matches are ignored in the same way.
- R5: With pulse mode 1, each enabled match sets the alarm flag and drives the pin low for PULSE_TICKS ticks. A match during a pulse restarts the count.
- R6: With pulse mode 0, an enabled match sets the alarm flag, and the pin stays low until that flag is cleared.
- R7: With battery silence 1 and `on_battery` high, the pin is held high whatever the wave or alarm state. With battery silence 0, the pin works normally in battery mode.
- R8: Status bit 7 is auto-clear. When it is 1, a `stat_rd_done` strobe clears flag bits 0 (battery), 1 (alarm) and 2 (event). When it is 0, the strobe has no effect.
- R9: The battery flag sets on a rising edge of `on_battery` and the event flag on `event_hit`. A status write with a 0 in a flag bit clears that flag. A 1 never sets a flag. A set in the same cycle as a clear wins.
- R10: The low-power bit is stored and read back but changes no pin behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc32k | input | 1 | 32768 Hz oscillator level, synchronous to clk |
| alarm_hit | input | 1 | One-cycle alarm-match strobe |
| event_hit | input | 1 | One-cycle event-detection strobe |
| on_battery | input | 1 | High while running from the backup supply |
| stat_rd_done | input | 1 | Strobe: a status read completed with a valid stop |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 1 | 0 selects control, 1 selects status |
| bus_wdata | input | 8 | Write data |
| ctrl_rd | output | 8 | Control register contents |
| stat_rd | output | 8 | Status register contents |
| irq_fout_n | output | 1 | Shared active-low interrupt / frequency pin |

## Verification
The bench builds the block with PULSE_TICKS at 16 instead of 8192. It toggles `osc32k` every cycle, so one tick lasts two clocks. With those settings, the full alarm pulse and a restarted pulse fit in a few dozen cycles and can be measured end to end. The divider keeps its real 20-bit width. Half-periods are measured exactly for 32768, 4096, 1024 and 64 Hz, which exercises both the pass-through path and the computed bit index.

// File: rtl/rtc_irq_fout.sv
module rtc_irq_fout #(
  parameter int PULSE_TICKS = 8192,
  parameter int DIV_W       = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc32k,
  input  logic       alarm_hit,
  input  logic       event_hit,
  input  logic       on_battery,
  input  logic       stat_rd_done,
  input  logic       bus_we,
  input  logic       bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] ctrl_rd,
  output logic [7:0] stat_rd,
  output logic       irq_fout_n
);
  localparam int PW = $clog2(PULSE_TICKS + 1);
  localparam logic [PW-1:0] PLOAD = PW'(PULSE_TICKS);

  logic [7:0]       ctrl_q;
  logic             osc_d, bat_d, tick;
  logic [DIV_W-1:0] div_q;
  logic [PW-1:0]    pulse_q;
  logic             batf, almf, evtf, arst_q;

  wire [3:0] fo     = ctrl_q[3:0];
  wire       pmode  = ctrl_q[7];
  wire       alme   = ctrl_q[6];
  wire       silent = ctrl_q[4] & on_battery;
  wire       alm_en = alme & (fo == 4'd0);
  wire       match  = alarm_hit & alm_en;
  wire       wr_ctl = bus_we & ~bus_sel;
  wire       wr_st  = bus_we & bus_sel;
  wire       fo_chg = wr_ctl & (bus_wdata[3:0] != fo);
  wire       autoc  = arst_q & stat_rd_done;
  wire       bat_set = on_battery & ~bat_d;

  assign tick = osc32k & ~osc_d;

  logic [4:0] bit_idx;
  always_comb begin
    case (fo)
      4'd2:    bit_idx = 5'd2;
      4'd3:    bit_idx = 5'd4;
      default: bit_idx = 5'({1'b0, fo}) + 5'd4;
    endcase
  end

  logic wave;
  always_comb begin
    if (fo == 4'd1) wave = osc_d;
    else            wave = div_q[bit_idx];
  end

  logic pin_next;
  always_comb begin
    if (silent)           pin_next = 1'b1;
    else if (fo != 4'd0)  pin_next = wave;
    else if (alme)        pin_next = pmode ? (pulse_q == '0) : ~almf;
    else                  pin_next = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      osc_d      <= 1'b0;
      bat_d      <= 1'b0;
      div_q      <= '0;
      pulse_q    <= '0;
      batf       <= 1'b0;
      almf       <= 1'b0;
      evtf       <= 1'b0;
      arst_q     <= 1'b0;
      irq_fout_n <= 1'b1;
    end else begin
      osc_d      <= osc32k;
      bat_d      <= on_battery;
      irq_fout_n <= pin_next;
      if (wr_ctl) ctrl_q <= bus_wdata;
      if (fo_chg)    div_q <= '0;
      else if (tick) div_q <= div_q + 1'b1;
      if (match && pmode)             pulse_q <= PLOAD;
      else if (tick && pulse_q != '0) pulse_q <= pulse_q - 1'b1;
      if (wr_st) arst_q <= bus_wdata[7];
      if (bat_set)                            batf <= 1'b1;
      else if (autoc || (wr_st && !bus_wdata[0])) batf <= 1'b0;
      if (match)                              almf <= 1'b1;
      else if (autoc || (wr_st && !bus_wdata[1])) almf <= 1'b0;
      if (event_hit)                          evtf <= 1'b1;
      else if (autoc || (wr_st && !bus_wdata[2])) evtf <= 1'b0;
    end
  end

  assign ctrl_rd = ctrl_q;
  assign stat_rd = {arst_q, 4'b0000, evtf, almf, batf};

  assert_pulse_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q != '0 && !tick && !alarm_hit) |=> $stable(pulse_q));
  assert_pulse_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q <= PLOAD);
  assert_level_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pmode && alm_en && !silent && almf) |=> !irq_fout_n);
  assert_fout_blocks_alarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_hit && fo != 4'd0 && !almf) |=> !almf);
  assert_fout_no_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_hit && fo != 4'd0 && pulse_q == '0) |=> pulse_q == '0);
  assert_battery_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[4] && on_battery) |=> irq_fout_n);
  assert_autoclear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_done && arst_q && !alarm_hit && !event_hit && !bat_set) |=> stat_rd[2:0] == 3'b000);
endmodule

// File: tb/rtc_irq_fout_tb.sv
module rtc_irq_fout_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PT = 16;

  logic clk = 1'b0, rst_n = 1'b0, osc32k = 1'b0, osc_run = 1'b0;
  logic alarm_hit = 1'b0, event_hit = 1'b0, on_battery = 1'b0, stat_rd_done = 1'b0;
  logic bus_we = 1'b0, bus_sel = 1'b0;
  logic [7:0] bus_wdata = '0, ctrl_rd, stat_rd;
  logic irq_fout_n;

  rtc_irq_fout #(.PULSE_TICKS(PT)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc32k(osc32k), .alarm_hit(alarm_hit),
    .event_hit(event_hit), .on_battery(on_battery), .stat_rd_done(stat_rd_done),
    .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .ctrl_rd(ctrl_rd), .stat_rd(stat_rd), .irq_fout_n(irq_fout_n));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (osc_run) osc32k <= ~osc32k;

  typedef struct { string req; int lo; int hi; } exp_t;
  exp_t exp_q[$];
  int   act_q[$];
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  always @(negedge clk) begin
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      exp_t e;
      int a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      n_chk++;
      if (a < e.lo || a > e.hi) begin
        n_bad++;
        $display("FAIL %s actual=%0d expected=%0d..%0d", e.req, a, e.lo, e.hi);
      end
    end
  end

  task automatic chk(string req, int act, int lo, int hi);
    exp_q.push_back('{req, lo, hi});
    act_q.push_back(act);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic strobe_alarm();
    @(negedge clk); alarm_hit = 1'b1;
    @(negedge clk); alarm_hit = 1'b0;
  endtask

  task automatic half_period(output int n);
    logic v;
    int guard;
    v = irq_fout_n; guard = 0;
    while (irq_fout_n == v && guard < 5000) begin @(negedge clk); guard++; end
    v = irq_fout_n; n = 0;
    while (irq_fout_n == v && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic low_run(int restart_at, output int n);
    int guard;
    guard = 0; n = 0;
    while (irq_fout_n && guard < 200) begin @(negedge clk); guard++; end
    while (!irq_fout_n && n < 500) begin
      if (restart_at > 0 && n == restart_at) alarm_hit = 1'b1;
      @(negedge clk);
      alarm_hit = 1'b0;
      n++;
    end
  endtask

  int m, lows;

  initial begin
    cyc(3);
    chk("R1 pin", irq_fout_n, 1, 1);
    chk("R1 ctrl", ctrl_rd, 0, 0);
    chk("R1 stat", stat_rd, 0, 0);
    rst_n = 1'b1;
    osc_run = 1'b1;
    cyc(2);

    wr(0, 8'hA0); cyc(1);
    chk("R2 ctrl readback", ctrl_rd, 8'hA0, 8'hA0);
    wr(0, 8'h00);

    wr(0, 8'h01); cyc(4); half_period(m); chk("R3 32768Hz half", m, 1, 1);
    wr(0, 8'h02); cyc(2);
    lows = 0; while (!irq_fout_n && lows < 50) begin @(negedge clk); lows++; end
    chk("R3 divider reset on code change", lows, 6, 9);
    half_period(m); chk("R3 4096Hz half", m, 8, 8);
    wr(0, 8'h03); half_period(m); half_period(m); chk("R3 1024Hz half", m, 32, 32);
    wr(0, 8'h04); half_period(m); half_period(m); chk("R3 64Hz half", m, 512, 512);

    wr(0, 8'h42); strobe_alarm(); cyc(2);
    chk("R4 fout blocks alarm flag", stat_rd[1], 0, 0);
    half_period(m); chk("R4 wave continues", m, 8, 8);
    wr(0, 8'h00); cyc(3); strobe_alarm(); cyc(3);
    chk("R4 alme=0 pin", irq_fout_n, 1, 1);
    chk("R4 alme=0 flag", stat_rd[1], 0, 0);

    wr(0, 8'h40); strobe_alarm(); cyc(3);
    chk("R6 flag set", stat_rd[1], 1, 1);
    cyc(100);
    chk("R6 pin held low", irq_fout_n, 0, 0);
    wr(1, 8'h00); cyc(2);
    chk("R6 released after clear", irq_fout_n, 1, 1);

    wr(0, 8'hC0);
    fork strobe_alarm(); join_none
    low_run(0, m); chk("R5 pulse width", m, 2*PT-1, 2*PT);
    chk("R5 flag set", stat_rd[1], 1, 1);
    cyc(4);
    fork strobe_alarm(); join_none
    low_run(10, m); chk("R5 restart extends pulse", m, 2*PT+8, 2*PT+12);
    wr(1, 8'h00);

    wr(0, 8'h50); strobe_alarm(); cyc(3);
    chk("R7 alarm low before battery", irq_fout_n, 0, 0);
    on_battery = 1'b1; cyc(3);
    chk("R7 silenced in battery", irq_fout_n, 1, 1);
    on_battery = 1'b0; cyc(3);
    chk("R7 resumes on mains", irq_fout_n, 0, 0);
    wr(0, 8'h40); on_battery = 1'b1; cyc(3);
    chk("R7 not silenced when bit clear", irq_fout_n, 0, 0);
    wr(0, 8'h11); cyc(2);
    lows = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (!irq_fout_n) lows++; end
    chk("R7 wave silenced", lows, 0, 0);
    on_battery = 1'b0;
    wr(0, 8'h00); wr(1, 8'h00); cyc(2);
    chk("R9 flags cleared by write 0", stat_rd, 0, 0);

    wr(1, 8'h07); cyc(1);
    chk("R9 write 1 does not set", stat_rd, 0, 0);
    on_battery = 1'b1; cyc(2);
    chk("R9 battery flag", stat_rd[0], 1, 1);
    @(negedge clk); event_hit = 1'b1; @(negedge clk); event_hit = 1'b0; cyc(1);
    chk("R9 event flag", stat_rd[2], 1, 1);
    wr(0, 8'h40); strobe_alarm(); cyc(1);
    chk("R9 all flags", stat_rd, 8'h07, 8'h07);

    @(negedge clk); stat_rd_done = 1'b1; @(negedge clk); stat_rd_done = 1'b0; cyc(1);
    chk("R8 no clear when auto off", stat_rd, 8'h07, 8'h07);
    wr(1, 8'h87); cyc(1);
    chk("R8 auto bit set, flags kept", stat_rd, 8'h87, 8'h87);
    @(negedge clk); stat_rd_done = 1'b1; @(negedge clk); stat_rd_done = 1'b0; cyc(1);
    chk("R8 flags cleared by read", stat_rd, 8'h80, 8'h80);
    on_battery = 1'b0;

    wr(0, 8'h60); cyc(1);
    chk("R10 low-power readback", ctrl_rd, 8'h60, 8'h60);
    strobe_alarm(); cyc(3);
    chk("R10 alarm level unaffected", irq_fout_n, 0, 0);
    wr(0, 8'h23); half_period(m); half_period(m);
    chk("R10 wave unaffected", m, 32, 32);

    cyc(3);
    done = 1;
  end

  initial begin
    int t;
    t = 0;
    while (!done && t < 150000) begin @(negedge clk); t++; end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    cyc(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule